// File: doc/BRIEF.md
# Tuner Synthesizer Phase Detector Core

This block is the digital heart of a frequency synthesizer loop for a tuner. It runs on the crystal-rate clock, divides that clock by a fixed reference ratio (32 by default, giving 125 kHz from a 4 MHz crystal), and divides a prescaled oscillator, delivered as a one-cycle tick per oscillator period, by a programmable 15-bit ratio. A tri-state frequency/phase detector compares the falling edges of the two divided signals. Its pump-up and pump-down enables, together with a high-impedance request, go to an external charge pump.

Two test bits pick one of four operating modes. The modes are normal operation, a forced high-impedance pump, export of the reference and divided signals on two port pins, and injection of both detector inputs from two external port inputs. The block also passes through the pump-current level select and the tune-disable control. Ports that are not exported drive the programmed open-collector levels.

Top module: `tpd_core`

## Requirements
- R1: The reference signal is the clock divided by REF_DIV. After reset release it falls once every REF_DIV clocks, and it is high in counts REF_DIV/2 to REF_DIV-1 of each period.
- R2: The divided signal falls once every N oscillator ticks, where N is the active 15-bit ratio. It is high from tick count N/2 of each period until the terminal count. The first period after reset uses N_MIN.
- R3: A requested ratio below N_MIN (256 by default) is used as N_MIN.
- R4: A new ratio takes effect only at a terminal count of the programmable divider. The period in progress finishes with the old ratio.
- R5: If the divided signal falls first, pump_up is high from the clock after that edge until the clock after the reference falls. In the reverse order, pump_dn is high for the same span. A second edge of the same input before the other input has fallen keeps the active output high.
- R6: Falling edges that arrive in the same clock cycle leave both pump_up and pump_dn low.
- R7: pump_up and pump_dn are never high together. pump_hiz is high whenever both are low.
- R8: With test_mode = 2'b01, pump_up and pump_dn are low and pump_hiz is high. The detector state keeps running and reappears when the mode is left.
- R9: With test_mode = 2'b10, port_out[0] carries the reference, port_out[1] carries the divided signal and port_out[2] carries port_drv[2]. In every other mode, port_out equals port_drv.
- R10: With test_mode = 2'b11, port_in[0] replaces the reference and port_in[1] replaces the divided signal at the detector inputs.
- R11: pump_hi_cur follows cur_hi, and tune_en is the inverse of tune_off.
- R12: During reset, pump_up and pump_dn are low, pump_hiz is high, and port_out equals port_drv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One pulse per prescaled oscillator period |
| ratio | input | NW | Requested programmable divide ratio |
| test_mode | input | 2 | Test bits: bit 1 = export/inject, bit 0 = pump off |
| cur_hi | input | 1 | Pump current level select (1 = high) |
| tune_off | input | 1 | Disables the tune output driver |
| port_drv | input | 3 | Programmed open-collector levels for the three ports |
| port_in | input | 2 | TTL levels read from port pins 0 and 1 |
| pump_up | output | 1 | Charge pump source enable |
| pump_dn | output | 1 | Charge pump sink enable |
| pump_hiz | output | 1 | Charge pump high-impedance request |
| pump_hi_cur | output | 1 | Selected pump current level |
| tune_en | output | 1 | Tune output driver enable |
| port_out | output | 3 | Drive levels for the three port pins |

## Verification
A divider counter that slips, or a ratio loaded away from the terminal count, moves a falling edge. Within one reference period, that shows up as a pump pulse of the wrong width or on the wrong side, and in export mode the port pins reveal the offset on the very next cycle. A detector flop that is not cleared, or that is cleared too early, leaves a pulse stuck high or missing at the first edge pair. A wrong mode decode shows up at once on pump_hiz or port_out.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

  typedef enum logic [1:0] {
    TM_NORMAL   = 2'b00,
    TM_PUMP_OFF = 2'b01,
    TM_EXPORT   = 2'b10,
    TM_EXT_IN   = 2'b11
  } test_mode_e;

  // ratio actually loaded into the divider for a requested value
  function automatic int unsigned eff_ratio(input int unsigned req, input int unsigned floor_val);
    return (req < floor_val) ? floor_val : req;
  endfunction

  // count at which a divided square wave turns high
  function automatic int unsigned high_start(input int unsigned period);
    return period / 2;
  endfunction

endpackage

// File: rtl/tpd_ref_div.sv
module tpd_ref_div #(
  parameter int REF_DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_sig
);
  localparam int RW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [RW-1:0] LAST  = RW'(REF_DIV - 1);
  localparam logic [RW-1:0] HI_AT = RW'(tpd_pkg::high_start(REF_DIV));

  logic [RW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign ref_sig = (cnt >= HI_AT);
endmodule

// File: rtl/tpd_prog_div.sv
module tpd_prog_div #(
  parameter int NW    = 15,
  parameter int N_MIN = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [NW-1:0] ratio,
  output logic          div_sig,
  output logic          div_wrap,
  output logic [NW-1:0] act_ratio
);
  logic [NW-1:0] cnt;
  logic [NW-1:0] req_eff;
  logic [NW-1:0] hi_at;

  assign req_eff  = NW'(tpd_pkg::eff_ratio(32'(ratio), N_MIN));
  assign div_wrap = tick && (cnt == act_ratio - 1'b1);
  assign hi_at    = NW'(tpd_pkg::high_start(32'(act_ratio)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_ratio <= NW'(N_MIN);
    end else if (tick) begin
      if (div_wrap) begin
        cnt       <= '0;
        act_ratio <= req_eff;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign div_sig = (cnt >= hi_at);
endmodule

// File: rtl/tpd_pfd.sv
module tpd_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic div_in,
  output logic up_q,
  output logic dn_q,
  output logic ref_fall,
  output logic div_fall
);
  logic ref_prev, div_prev;
  logic up_nx, dn_nx, both;

  assign ref_fall = ref_prev & ~ref_in;
  assign div_fall = div_prev & ~div_in;

  always_comb begin
    up_nx = up_q | div_fall;
    dn_nx = dn_q | ref_fall;
    both  = up_nx & dn_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_prev <= 1'b0;
      div_prev <= 1'b0;
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
    end else begin
      ref_prev <= ref_in;
      div_prev <= div_in;
      up_q     <= up_nx & ~both;
      dn_q     <= dn_nx & ~both;
    end
  end
endmodule

// File: rtl/tpd_core.sv
module tpd_core #(
  parameter int REF_DIV = 32,
  parameter int NW      = 15,
  parameter int N_MIN   = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_tick,
  input  logic [NW-1:0] ratio,
  input  logic [1:0]    test_mode,
  input  logic          cur_hi,
  input  logic          tune_off,
  input  logic [2:0]    port_drv,
  input  logic [1:0]    port_in,
  output logic          pump_up,
  output logic          pump_dn,
  output logic          pump_hiz,
  output logic          pump_hi_cur,
  output logic          tune_en,
  output logic [2:0]    port_out
);
  import tpd_pkg::*;

  test_mode_e    tm;
  logic          ref_sig, div_sig, div_wrap;
  logic [NW-1:0] act_ratio;
  logic          sel_ref, sel_div;
  logic          up_q, dn_q, ref_fall, div_fall;
  logic          pump_off;

  assign tm = test_mode_e'(test_mode);

  tpd_ref_div #(.REF_DIV(REF_DIV)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_sig(ref_sig)
  );

  tpd_prog_div #(.NW(NW), .N_MIN(N_MIN)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .ratio(ratio),
    .div_sig(div_sig), .div_wrap(div_wrap), .act_ratio(act_ratio)
  );

  // detector input routing: internal signals or external port inputs
  assign sel_ref = (tm == TM_EXT_IN) ? port_in[0] : ref_sig;
  assign sel_div = (tm == TM_EXT_IN) ? port_in[1] : div_sig;

  tpd_pfd u_pfd (
    .clk(clk), .rst_n(rst_n), .ref_in(sel_ref), .div_in(sel_div),
    .up_q(up_q), .dn_q(dn_q), .ref_fall(ref_fall), .div_fall(div_fall)
  );

  assign pump_off    = (tm == TM_PUMP_OFF);
  assign pump_up     = up_q & ~pump_off;
  assign pump_dn     = dn_q & ~pump_off;
  assign pump_hiz    = pump_off | ~(up_q | dn_q);
  assign pump_hi_cur = cur_hi;
  assign tune_en     = ~tune_off;

  always_comb begin
    port_out = port_drv;
    if (tm == TM_EXPORT) begin
      port_out[0] = ref_sig;
      port_out[1] = div_sig;
    end
  end
endmodule

// File: rtl/tpd_core_chk.sv
module tpd_core_chk #(
  parameter int NW    = 15,
  parameter int N_MIN = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    test_mode,
  input logic          pump_up,
  input logic          pump_dn,
  input logic          pump_hiz,
  input logic          up_q,
  input logic          dn_q,
  input logic          ref_fall,
  input logic          div_fall,
  input logic          div_wrap,
  input logic [NW-1:0] act_ratio
);
  // R7
  no_dual_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  // R7
  idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pump_up && !pump_dn) |-> pump_hiz);

  // R8
  forced_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode == 2'b01) |-> (pump_hiz && !pump_up && !pump_dn));

  // R4
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_wrap |=> $stable(act_ratio));

  // R3
  ratio_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_ratio >= NW'(N_MIN));

  // R5
  dn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_q) |-> ($past(ref_fall) && !$past(div_fall)));

  // R5
  up_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> ($past(div_fall) && !$past(ref_fall)));

  // R6
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_fall && div_fall && !up_q && !dn_q) |=> (!up_q && !dn_q));
endmodule

bind tpd_core tpd_core_chk #(.NW(NW), .N_MIN(N_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
  .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
  .up_q(up_q), .dn_q(dn_q), .ref_fall(ref_fall), .div_fall(div_fall),
  .div_wrap(div_wrap), .act_ratio(act_ratio)
);

// File: tb/sim_tpd_core.sv
module sim_tpd_core;
  localparam int R    = 8;
  localparam int NW   = 6;
  localparam int NMIN = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          osc_tick;
  logic [NW-1:0] ratio;
  logic [1:0]    test_mode;
  logic          cur_hi, tune_off;
  logic [2:0]    port_drv;
  logic [1:0]    port_in;
  logic          pump_up, pump_dn, pump_hiz, pump_hi_cur, tune_en;
  logic [2:0]    port_out;

  tpd_core #(.REF_DIV(R), .NW(NW), .N_MIN(NMIN)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ratio(ratio),
    .test_mode(test_mode), .cur_hi(cur_hi), .tune_off(tune_off),
    .port_drv(port_drv), .port_in(port_in),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
    .pump_hi_cur(pump_hi_cur), .tune_en(tune_en), .port_out(port_out)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // behavioural model state
  int  e, tc, base, per, target;
  bit  m_up, m_dn, rf, df, s_ref, s_div;
  bit  a_tick;
  int  a_ratio;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int clampr(input int r);
    return (r < NMIN) ? NMIN : r;
  endfunction

  task automatic lfsr_step;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic chk(input string name, input string tag, input int got, input int exp);
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, name, got, exp, e);
    end
  endtask

  task automatic cycle(input logic [1:0] mode, input int ratio_v, input bit tick_v,
                       input logic [1:0] ext_v, input string tag);
    bit nu, nd, ref_m, div_m, p_ref, p_div;
    logic [2:0] exp_port;
    @(posedge clk);
    // detector: edges seen in the previous interval act at this edge
    nu = m_up | df;
    nd = m_dn | rf;
    if (nu && nd) begin nu = 0; nd = 0; end
    m_up = nu; m_dn = nd;
    p_ref = s_ref; p_div = s_div;
    e++;
    if (a_tick) begin
      tc++;
      if (tc == target) begin
        per = clampr(a_ratio); base = tc; target = tc + per;
      end
    end
    #1;
    lfsr_step;
    test_mode = mode; ratio = NW'(ratio_v); osc_tick = tick_v; port_in = ext_v;
    cur_hi = lfsr[0]; tune_off = lfsr[1]; port_drv = lfsr[4:2];
    a_tick = tick_v; a_ratio = ratio_v;
    ref_m = ((e % R) >= R / 2);
    div_m = ((tc - base) >= per / 2);
    s_ref = (mode == 2'b11) ? ext_v[0] : ref_m;
    s_div = (mode == 2'b11) ? ext_v[1] : div_m;
    rf = p_ref & ~s_ref;
    df = p_div & ~s_div;
    #4;
    vectors++;
    chk("pump_up", tag, pump_up, (m_up && mode != 2'b01));
    chk("pump_dn", tag, pump_dn, (m_dn && mode != 2'b01));
    chk("pump_hiz", (mode == 2'b01) ? "R8" : "R7", pump_hiz, (mode == 2'b01) || !(m_up || m_dn));
    exp_port = (mode == 2'b10) ? {port_drv[2], div_m, ref_m} : port_drv;
    chk("port_out", "R9", port_out, exp_port);
    chk("pump_hi_cur", "R11", pump_hi_cur, cur_hi);
    chk("tune_en", "R11", tune_en, !tune_off);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    logic [1:0] ext_hold;
    rst_n = 1'b0; osc_tick = 1'b1; ratio = NW'(8); test_mode = 2'b00;
    cur_hi = 1'b0; tune_off = 1'b0; port_drv = 3'b101; port_in = 2'b00;
    repeat (3) @(posedge clk);
    #5;
    // R12 reset state
    vectors++;
    chk("pump_up", "R12", pump_up, 0);
    chk("pump_dn", "R12", pump_dn, 0);
    chk("pump_hiz", "R12", pump_hiz, 1);
    chk("port_out", "R12", port_out, 3'b101);
    e = 0; tc = 0; base = 0; per = NMIN; target = NMIN;
    m_up = 0; m_dn = 0; rf = 0; df = 0; s_ref = 0; s_div = 0;
    a_tick = 1; a_ratio = 8;
    rst_n = 1'b1;

    ext_hold = 2'b00;
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < 600; i++) begin
        if (i % 3 == 0) ext_hold = (p == 7) ? {lfsr[8], lfsr[8]} : lfsr[9:8];
        case (p)
          0: cycle(2'b00, 8, 1'b1, ext_hold, "R1");
          1: cycle(2'b00, 12, 1'b1, ext_hold, "R5");
          2: cycle(2'b00, 5, 1'b1, ext_hold, "R5");
          3: cycle(2'b00, 2, 1'b1, ext_hold, "R3");
          4: cycle(2'b10, 6, lfsr[7], ext_hold, "R9");
          5: cycle(2'b01, 9, 1'b1, ext_hold, "R8");
          6: cycle(2'b11, 8, 1'b1, ext_hold, "R10");
          default: cycle(2'b11, 8, 1'b1, ext_hold, "R6");
        endcase
      end
    end
    // ratio sweep with irregular ticks, ratio changed mid-period
    for (int n = 0; n < 64; n++) begin
      for (int i = 0; i < 120; i++) begin
        cycle((n % 4 == 1) ? 2'b10 : 2'b00, n, lfsr[6] | lfsr[11], 2'b00, "R2 R4");
      end
    end
    done = 1;
    summary;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      summary;
      $finish;
    end
  end
endmodule